// File: doc/BRIEF.md
# Startup and Brown-out Sequencer

This block is the supervisor that decides when a current-mode switching controller may start to pulse. It combines three conditions into a single sequence: a supply-good flag from an undervoltage comparator, a line-voltage-good flag from a brown-out comparator, and a completion flag from the soft-start comparator. While switching is not allowed, it holds the soft-start capacitor discharged. When all conditions are met, it releases the ramp and clamps the peak-current reference to a quarter of the ramp level. After the ramp reports completion, it hands the full reference to the current loop.

A supply power-up can be followed by an optional fixed hold-off, chosen by a configuration input, so that an upstream stage has time to settle. The hold-off is never used after a brown-out recovery: in that case, a new soft start begins as soon as the line returns. Each brown-out shutdown issues a one-cycle clear pulse, which the fault latch uses to drop a latched overload.

Top module: `startup_sequencer`

## Requirements
- R1: While `rst` is high, and on the cycle after `supply_ok` is sampled low, the outputs are `switch_en`=0, `ramp_discharge`=1, `peak_limit`=0 and `bo_clear_pulse`=0.
- R2: With `delay_en`=1, after `supply_ok` is sampled high, the block keeps `switch_en`=0 and `ramp_discharge`=1 for DELAY_CYCLES+1 cycles whatever `brownout_ok` does. During this time it issues no clear pulse.
- R3: With `delay_en`=0 and `brownout_ok`=1, `switch_en` rises on the second cycle after `supply_ok` is sampled high.
- R4: If `brownout_ok` is low when the hold-off ends, switching stays off until `brownout_ok` is sampled high. `switch_en` rises on the following cycle.
- R5: When `brownout_ok` is sampled low while switching, the next cycle has `switch_en`=0 and `ramp_discharge`=1.
- R6: Every shutdown caused by `brownout_ok` raises `bo_clear_pulse` for exactly one cycle, in the first cycle of the shutdown.
- R7: After a brown-out shutdown, `brownout_ok` sampled high restarts soft start on the next cycle. No hold-off is applied, even with `delay_en`=1.
- R8: During soft start, `ramp_done` sampled high moves the block to run. In run, `peak_limit` equals the full-scale value (all ones), and a later low `ramp_done` does not change this.
- R9: During soft start, `peak_limit` equals `ramp_level` shifted right by 2 (level divided by 4). `peak_limit` is 0 whenever switching is off.
- R10: A supply loss from run returns the block to lockout without a clear pulse. The next power-up with `delay_en`=1 applies the full hold-off again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply above the undervoltage turn-on level |
| brownout_ok | input | 1 | Line-voltage image above the brown-out level |
| ramp_done | input | 1 | Soft-start ramp has passed its completion level |
| delay_en | input | 1 | Enables the fixed hold-off after supply power-up |
| ramp_level | input | LVL_W | Digitised soft-start ramp level |
| ramp_discharge | output | 1 | Command to hold the soft-start capacitor grounded |
| switch_en | output | 1 | Gate-drive pulses allowed |
| peak_limit | output | LVL_W | Peak-current reference for the current comparator |
| bo_clear_pulse | output | 1 | One-cycle clear for the fault latch on brown-out |

## Verification
Several behaviours are checked by assertions on every cycle:
- quiet outputs after a supply loss;
- shutdown within one cycle of a brown-out;
- the single-cycle width of the clear pulse and the shutdown it must accompany;
- the immediate resumption from a brown-out stop;
- the hold-off counter staying in range.

Other behaviours can only be shown by the bench scenarios, because they depend on a whole history of inputs:
- the exact length of the hold-off;
- the choice between the delayed and undelayed start;
- the wait for the line after the hold-off;
- the quarter-scale reference during the ramp;
- the restart of the hold-off after a second power-up.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [2:0] {
        ST_LOCKOUT   = 3'd0,
        ST_DELAY     = 3'd1,
        ST_WAIT_BO   = 3'd2,
        ST_SOFTSTART = 3'd3,
        ST_RUN       = 3'd4,
        ST_BO_OFF    = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        LIM_ZERO = 2'd0,
        LIM_RAMP = 2'd1,
        LIM_FULL = 2'd2
    } limit_mode_e;

    typedef struct packed {
        logic discharge;
        logic switching;
    } seq_drive_t;

    function automatic seq_drive_t drive_of(seq_state_e s);
        seq_drive_t d;
        d.switching = (s == ST_SOFTSTART) || (s == ST_RUN);
        d.discharge = !d.switching;
        return d;
    endfunction

    function automatic limit_mode_e limit_of(seq_state_e s);
        case (s)
            ST_SOFTSTART: return LIM_RAMP;
            ST_RUN:       return LIM_FULL;
            default:      return LIM_ZERO;
        endcase
    endfunction

endpackage

// File: rtl/sup_delay_timer.sv
module sup_delay_timer #(
    parameter int DELAY_CYCLES = 6000000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    generate
        if (DELAY_CYCLES <= 1) begin : g_short
            assign expired = run;
        end else begin : g_count
            localparam int CNT_W = $clog2(DELAY_CYCLES + 1);
            localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYCLES - 1);
            logic [CNT_W-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    cnt <= '0;
                end else if (cnt != LAST) begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign expired = run && (cnt == LAST);

            AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
                cnt <= LAST); // R2
        end
    endgenerate
endmodule

// File: rtl/sup_ctrl_fsm.sv
module sup_ctrl_fsm
    import sup_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_ok,
    input  logic       brownout_ok,
    input  logic       ramp_done,
    input  logic       delay_en,
    input  logic       delay_expired,
    output seq_state_e state,
    output logic       bo_clear_pulse
);
    seq_state_e nxt;

    always_comb begin
        nxt = state;
        if (!supply_ok) begin
            nxt = ST_LOCKOUT;
        end else begin
            case (state)
                ST_LOCKOUT:   nxt = delay_en ? ST_DELAY : ST_WAIT_BO;
                ST_DELAY:     if (delay_expired) nxt = ST_WAIT_BO;
                ST_WAIT_BO:   if (brownout_ok) nxt = ST_SOFTSTART;
                ST_SOFTSTART: begin
                    if (!brownout_ok)   nxt = ST_BO_OFF;
                    else if (ramp_done) nxt = ST_RUN;
                end
                ST_RUN:       if (!brownout_ok) nxt = ST_BO_OFF;
                ST_BO_OFF:    if (brownout_ok) nxt = ST_SOFTSTART;
                default:      nxt = ST_LOCKOUT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state          <= ST_LOCKOUT;
            bo_clear_pulse <= 1'b0;
        end else begin
            state          <= nxt;
            bo_clear_pulse <= (nxt == ST_BO_OFF) && (state != ST_BO_OFF);
        end
    end

    AST_RESUME_NO_DELAY: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BO_OFF) && brownout_ok && supply_ok |=> state == ST_SOFTSTART); // R7

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        bo_clear_pulse |=> !bo_clear_pulse); // R6

    AST_PULSE_IN_SHUTDOWN: assert property (@(posedge clk) disable iff (rst)
        bo_clear_pulse |-> state == ST_BO_OFF); // R6
endmodule

// File: rtl/sup_limit_scaler.sv
module sup_limit_scaler
    import sup_pkg::*;
#(
    parameter int LVL_W = 10,
    parameter int SHIFT = 2
) (
    input  limit_mode_e      mode,
    input  logic [LVL_W-1:0] level,
    output logic [LVL_W-1:0] limit
);
    localparam logic [LVL_W-1:0] FULL_SCALE = {LVL_W{1'b1}};

    always_comb begin
        case (mode)
            LIM_RAMP: limit = level >> SHIFT;
            LIM_FULL: limit = FULL_SCALE;
            default:  limit = '0;
        endcase
    end
endmodule

// File: rtl/startup_sequencer.sv
module startup_sequencer
    import sup_pkg::*;
#(
    parameter int DELAY_CYCLES = 6000000,
    parameter int LVL_W        = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             supply_ok,
    input  logic             brownout_ok,
    input  logic             ramp_done,
    input  logic             delay_en,
    input  logic [LVL_W-1:0] ramp_level,
    output logic             ramp_discharge,
    output logic             switch_en,
    output logic [LVL_W-1:0] peak_limit,
    output logic             bo_clear_pulse
);
    localparam int RAMP_SHIFT = 2;

    seq_state_e state;
    seq_drive_t drv;
    logic       delay_expired;

    sup_delay_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (state == ST_DELAY),
        .expired (delay_expired)
    );

    sup_ctrl_fsm u_fsm (
        .clk            (clk),
        .rst            (rst),
        .supply_ok      (supply_ok),
        .brownout_ok    (brownout_ok),
        .ramp_done      (ramp_done),
        .delay_en       (delay_en),
        .delay_expired  (delay_expired),
        .state          (state),
        .bo_clear_pulse (bo_clear_pulse)
    );

    sup_limit_scaler #(.LVL_W(LVL_W), .SHIFT(RAMP_SHIFT)) u_limit (
        .mode  (limit_of(state)),
        .level (ramp_level),
        .limit (peak_limit)
    );

    assign drv            = drive_of(state);
    assign switch_en      = drv.switching;
    assign ramp_discharge = drv.discharge;

    AST_LOCKOUT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> !switch_en && ramp_discharge && !bo_clear_pulse); // R1

    AST_BO_SHUTDOWN: assert property (@(posedge clk) disable iff (rst)
        switch_en && !brownout_ok |=> !switch_en && ramp_discharge); // R5

    AST_PULSE_AFTER_SWITCHING: assert property (@(posedge clk) disable iff (rst)
        bo_clear_pulse |-> $past(switch_en) && !switch_en); // R6
endmodule

// File: tb/startup_sequencer_tb.sv
module startup_sequencer_tb;
    localparam int N  = 20;
    localparam int LW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          supply_ok = 1'b0, brownout_ok = 1'b0, ramp_done = 1'b0, delay_en = 1'b0;
    logic [LW-1:0] ramp_level = '0;
    logic          ramp_discharge, switch_en, bo_clear_pulse;
    logic [LW-1:0] peak_limit;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    startup_sequencer #(.DELAY_CYCLES(N), .LVL_W(LW)) u_dut (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .brownout_ok(brownout_ok),
        .ramp_done(ramp_done), .delay_en(delay_en), .ramp_level(ramp_level),
        .ramp_discharge(ramp_discharge), .switch_en(switch_en),
        .peak_limit(peak_limit), .bo_clear_pulse(bo_clear_pulse)
    );

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; supply_ok = 0; brownout_ok = 0; ramp_done = 0; delay_en = 0;
        ramp_level = '0;
        tick(2);
        rst = 1'b0;
    endtask

    task automatic reach_run();
        do_reset();
        delay_en = 0; brownout_ok = 1; ramp_level = 10'd200; supply_ok = 1;
        tick(2);
        ramp_done = 1;
        tick(1);
        ramp_done = 0;
    endtask

    task automatic t_reset();
        rst = 1'b1; supply_ok = 1; brownout_ok = 1; ramp_level = 10'd800;
        tick(2);
        chk("R1 switch_en in reset", switch_en, 0);
        chk("R1 discharge in reset", ramp_discharge, 1);
        chk("R1 limit in reset", peak_limit, 0);
        chk("R1 pulse in reset", bo_clear_pulse, 0);
    endtask

    task automatic t_delay_start();
        int bad_sw = 0;
        int bad_pl = 0;
        do_reset();
        delay_en = 1; brownout_ok = 1; supply_ok = 1;
        for (int i = 1; i <= N + 1; i++) begin
            brownout_ok = (i % 5 != 3);
            tick(1);
            if (switch_en || !ramp_discharge) bad_sw++;
            if (bo_clear_pulse) bad_pl++;
        end
        brownout_ok = 1;
        chk("R2 hold-off keeps switching off", bad_sw, 0);
        chk("R2 no pulse during hold-off", bad_pl, 0);
        tick(1);
        chk("R2 switching after hold-off", switch_en, 1);
    endtask

    task automatic t_no_delay();
        do_reset();
        delay_en = 0; brownout_ok = 1; supply_ok = 1;
        tick(1);
        chk("R3 off on first cycle", switch_en, 0);
        tick(1);
        chk("R3 on at second cycle", switch_en, 1);
        chk("R3 discharge released", ramp_discharge, 0);
    endtask

    task automatic t_wait_bo();
        do_reset();
        delay_en = 1; brownout_ok = 0; supply_ok = 1;
        tick(N + 6);
        chk("R4 waits for line", switch_en, 0);
        chk("R4 discharge while waiting", ramp_discharge, 1);
        brownout_ok = 1;
        tick(1);
        chk("R4 starts after line returns", switch_en, 1);
    endtask

    task automatic t_limit();
        int lv[4] = '{0, 7, 402, 1023};
        do_reset();
        chk("R9 zero limit when off", peak_limit, 0);
        delay_en = 0; brownout_ok = 1; supply_ok = 1;
        tick(2);
        foreach (lv[k]) begin
            ramp_level = LW'(lv[k]);
            tick(1);
            chk("R9 quarter of ramp", peak_limit, lv[k] / 4);
        end
    endtask

    task automatic t_run();
        reach_run();
        chk("R8 full scale in run", peak_limit, 1023);
        ramp_level = 10'd40;
        tick(3);
        chk("R8 stays in run", peak_limit, 1023);
        chk("R8 switching in run", switch_en, 1);
    endtask

    task automatic t_brownout();
        reach_run();
        delay_en = 1;
        brownout_ok = 0;
        tick(1);
        chk("R5 off after brown-out", switch_en, 0);
        chk("R5 discharge after brown-out", ramp_discharge, 1);
        chk("R6 clear pulse raised", bo_clear_pulse, 1);
        tick(1);
        chk("R6 clear pulse one cycle", bo_clear_pulse, 0);
        brownout_ok = 1; ramp_level = 10'd100;
        tick(1);
        chk("R7 immediate restart", switch_en, 1);
        chk("R7 restarts in soft start", peak_limit, 25);
        brownout_ok = 0;
        tick(1);
        chk("R6 pulse on second shutdown", bo_clear_pulse, 1);
        chk("R5 off from soft start", switch_en, 0);
        brownout_ok = 1;
        tick(1);
    endtask

    task automatic t_supply_drop();
        reach_run();
        supply_ok = 0;
        tick(1);
        chk("R10 lockout on supply loss", switch_en, 0);
        chk("R10 no pulse on supply loss", bo_clear_pulse, 0);
        chk("R1 limit zero in lockout", peak_limit, 0);
        delay_en = 1; supply_ok = 1;
        tick(N + 1);
        chk("R10 hold-off repeats", switch_en, 0);
        tick(1);
        chk("R10 start after repeated hold-off", switch_en, 1);
    endtask

    bit done = 0;

    initial begin
        t_reset();
        t_delay_start();
        t_no_delay();
        t_wait_bo();
        t_limit();
        t_run();
        t_brownout();
        t_supply_drop();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule